// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Guard

This block sits between the command scheduler of an SDRAM controller and the device command bus. The scheduler presents one request at a time, either a read or a write, together with the burst-length code and the CAS latency currently programmed. The guard passes reads through at once. It holds a write back until the data bus can no longer collide with the read burst that came before it.

For bursts of 1, 2, 4 or 8 words, a write may cut into a read only once the read is at least burst length plus one cycles behind it. A full-page read never ends on its own. When a write is waiting behind one, the guard first places a single burst-stop command on the bus. It then lets the write go once the CAS-latency drain has passed. Only CAS latency 3 is supported. Any other latency blocks every write and raises a flag.

A release indication marks the cycles in which the controller must mask the remaining beats of an interrupted read. The guard only ever emits NOP, READ, WRITE or BURST STOP.

Top module: `sdram_rw_guard`

## Requirements
- R1: A read request (reqValid high, reqIsWrite low) is accepted in the same cycle (reqAccept high), and cmdOut shows READ (code 1) in the following cycle.
- R2: For burst codes 0 to 3 (burst length 1, 2, 4, 8 = 1 shifted left by the code), WRITE (code 2) never appears on cmdOut fewer than burst length plus one cycles after READ appeared on cmdOut. A write already waiting is issued at exactly that cycle. A later one is issued in the cycle after it is presented.
- R3: A write that cannot go yet is stalled, not dropped: reqAccept stays low and cmdOut shows NOP (code 0) until the write is issued.
- R4: For burst codes 4 to 7 (full page), a write presented after a read produces exactly one BURST STOP (code 3) in the next cycle. WRITE follows 3 cycles after the BURST STOP, with NOP in between.
- R5: writeReady is high exactly in the cycles where a write request would be accepted. An accepted write shows WRITE on cmdOut in the next cycle. Before any read, writes are ready at once.
- R6: When casLat is not 3, unsupported is high and writeReady is low. No WRITE or BURST STOP is issued, but reads are still accepted. Once casLat returns to 3, a held write is issued in the next cycle.
- R7: dqRelease is high from the cycle WRITE appears until the cycle that lies burst length plus 2 cycles after the READ, inclusive. It is low at all other times, and always low for full-page reads ended by BURST STOP.
- R8: After reset cmdOut is NOP, dqRelease is low, and writeReady is high with casLat at 3. With no request, cmdOut shows NOP in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present, held until accepted |
| reqIsWrite | input | 1 | 1 = write request, 0 = read request |
| burstCode | input | 3 | Burst length code: 0..3 give 1,2,4,8; 4..7 full page |
| casLat | input | 2 | Programmed CAS latency (only 3 supported) |
| reqAccept | output | 1 | Request consumed this cycle |
| cmdOut | output | 2 | Command on the bus: 0 NOP, 1 READ, 2 WRITE, 3 BURST STOP |
| writeReady | output | 1 | A write would be accepted this cycle |
| dqRelease | output | 1 | Mask the remaining read beats on DQ |
| unsupported | output | 1 | casLat is not the supported value |

## Verification
Every fixed burst length is tried with the write presented at each offset from the read cycle up to two past the minimum spacing. This separates the case where the guard must stall the write from the case where it must pass the write through without an extra cycle. It also places the release window against both early and late writes.

Full-page codes are tried with the write arriving at several offsets, which shows that the burst stop is issued exactly once and that the drain is counted from the stop, not from the read. A write straight after reset shows that the guard does not stall with no read history. A run at an unsupported latency shows that writes are held while reads still pass, and that the held write is released once the latency is set back to 3.

// File: rtl/sdram_rw_pkg.sv
`timescale 1ns/1ps
package sdram_rw_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_BSTOP = 2'd3
  } cmd_e;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic doRead;
    logic doWrite;
    logic doStop;
  } strobe_t;

  localparam int FULL_CODE_MIN = 4;

endpackage

// File: rtl/sdram_rw_ctrl.sv
`timescale 1ns/1ps
module sdram_rw_ctrl
  import sdram_rw_pkg::*;
#(
  parameter int CL_W  = 2,
  parameter int CL_OK = 3
) (
  input  logic            reqValid,
  input  logic            reqIsWrite,
  input  logic [CL_W-1:0] casLat,
  input  logic            gapMet,
  input  logic            fpOpen,
  output strobe_t         stb,
  output logic            reqAccept,
  output logic            writeReady,
  output logic            unsupported
);

  logic supported;
  logic wantWrite;

  always_comb begin
    supported   = (casLat == CL_W'(CL_OK));
    unsupported = !supported;
    wantWrite   = reqValid && reqIsWrite;
    // a write may go only once spacing is met and no full-page burst is open
    writeReady  = supported && !fpOpen && gapMet;
    stb.doRead  = reqValid && !reqIsWrite;
    stb.doWrite = wantWrite && writeReady;
    stb.doStop  = wantWrite && supported && fpOpen;
    reqAccept   = stb.doRead || stb.doWrite;
  end

endmodule

// File: rtl/sdram_rw_dp.sv
`timescale 1ns/1ps
module sdram_rw_dp
  import sdram_rw_pkg::*;
#(
  parameter int GAP_W  = 5,
  parameter int CODE_W = 3,
  parameter int CL_OK  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [CODE_W-1:0] burstCode,
  output cmd_e              cmdOut,
  output logic              gapMet,
  output logic              fpOpen,
  output logic              dqRelease
);

  localparam logic [GAP_W-1:0] GAP_MAX  = '1;
  localparam logic [GAP_W:0]   ONE_W    = (GAP_W+1)'(1);
  localparam logic [GAP_W:0]   TAIL_W   = (GAP_W+1)'(CL_OK - 1);

  logic [GAP_W-1:0] gap;      // cycles since the last READ or BURST STOP on the bus
  logic [GAP_W-1:0] need;     // spacing the next WRITE must respect
  logic [GAP_W-1:0] blReg;    // burst length of the last read
  logic             stopped;  // last burst ended by BURST STOP
  logic             wrote;    // a WRITE followed the last read
  logic             fullNew;
  logic [GAP_W-1:0] blNew;
  logic [GAP_W-1:0] gapInc;

  always_comb begin
    fullNew   = (int'(burstCode) >= FULL_CODE_MIN);
    blNew     = fullNew ? '0 : (GAP_W'(1) << burstCode);
    gapInc    = (gap == GAP_MAX) ? gap : gap + GAP_W'(1);
    gapMet    = ({1'b0, gap} + ONE_W) >= {1'b0, need};
    dqRelease = wrote && !stopped && ({1'b0, gap} <= ({1'b0, blReg} + TAIL_W));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdOut  <= CMD_NOP;
      gap     <= GAP_MAX;
      need    <= '0;
      blReg   <= '0;
      fpOpen  <= 1'b0;
      stopped <= 1'b0;
      wrote   <= 1'b0;
    end else begin
      if (stb.doRead)       cmdOut <= CMD_READ;
      else if (stb.doStop)  cmdOut <= CMD_BSTOP;
      else if (stb.doWrite) cmdOut <= CMD_WRITE;
      else                  cmdOut <= CMD_NOP;

      if (stb.doRead) begin
        gap     <= '0;
        need    <= blNew + GAP_W'(1);
        blReg   <= blNew;
        fpOpen  <= fullNew;
        stopped <= 1'b0;
        wrote   <= 1'b0;
      end else if (stb.doStop) begin
        gap     <= '0;
        need    <= GAP_W'(CL_OK);
        fpOpen  <= 1'b0;
        stopped <= 1'b1;
      end else begin
        gap <= gapInc;
        if (stb.doWrite) wrote <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdram_rw_guard.sv
`timescale 1ns/1ps
module sdram_rw_guard
  import sdram_rw_pkg::*;
#(
  parameter int GAP_W  = 5,
  parameter int CODE_W = 3,
  parameter int CL_W   = 2,
  parameter int CL_OK  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsWrite,
  input  logic [CODE_W-1:0] burstCode,
  input  logic [CL_W-1:0]   casLat,
  output logic              reqAccept,
  output logic [1:0]        cmdOut,
  output logic              writeReady,
  output logic              dqRelease,
  output logic              unsupported
);

  strobe_t stb;
  cmd_e    cmdInt;
  logic    gapMet;
  logic    fpOpen;

  sdram_rw_ctrl #(.CL_W(CL_W), .CL_OK(CL_OK)) u_ctrl (
    .reqValid    (reqValid),
    .reqIsWrite  (reqIsWrite),
    .casLat      (casLat),
    .gapMet      (gapMet),
    .fpOpen      (fpOpen),
    .stb         (stb),
    .reqAccept   (reqAccept),
    .writeReady  (writeReady),
    .unsupported (unsupported)
  );

  sdram_rw_dp #(.GAP_W(GAP_W), .CODE_W(CODE_W), .CL_OK(CL_OK)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .burstCode (burstCode),
    .cmdOut    (cmdInt),
    .gapMet    (gapMet),
    .fpOpen    (fpOpen),
    .dqRelease (dqRelease)
  );

  assign cmdOut = cmdInt;

endmodule

// File: rtl/sdram_rw_guard_chk.sv
`timescale 1ns/1ps
module sdram_rw_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqIsWrite,
  input logic [2:0] burstCode,
  input logic [1:0] casLat,
  input logic       reqAccept,
  input logic [1:0] cmdOut,
  input logic       writeReady,
  input logic       dqRelease,
  input logic       unsupported
);

  logic [5:0] cnt;
  logic [5:0] bl;
  logic       fp;
  logic       seenRead;
  logic       stopSeen;
  logic [5:0] sinceStop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= 6'd63;
      bl        <= 6'd0;
      fp        <= 1'b0;
      seenRead  <= 1'b0;
      stopSeen  <= 1'b0;
      sinceStop <= 6'd63;
    end else begin
      if (reqValid && !reqIsWrite) begin
        cnt      <= 6'd0;
        bl       <= 6'd1 << burstCode[1:0];
        fp       <= burstCode[2];
        seenRead <= 1'b1;
        stopSeen <= 1'b0;
      end else begin
        if (cnt != 6'd63) cnt <= cnt + 6'd1;
        if (cmdOut == 2'd3) stopSeen <= 1'b1;
      end
      if (cmdOut == 2'd3) sinceStop <= 6'd1;
      else if (sinceStop != 6'd63) sinceStop <= sinceStop + 6'd1;
    end
  end

  a_r1_read_issue: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsWrite) |-> (reqAccept ##1 cmdOut == 2'd1));

  a_r2_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == 2'd2 && seenRead && !fp) |-> (cnt >= bl + 6'd1));

  a_r4_stop_first: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == 2'd2 && seenRead && fp) |-> (stopSeen && sinceStop >= 6'd3));

  a_r5_accept_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsWrite && writeReady) |=> (cmdOut == 2'd2));

  a_r6_unsupported: assert property (@(posedge clk) disable iff (!rstN)
    (casLat != 2'd3) |-> (unsupported && !writeReady && !(reqAccept && reqIsWrite)));

  a_r7_release_window: assert property (@(posedge clk) disable iff (!rstN)
    dqRelease |-> (seenRead && !fp && cnt <= bl + 6'd2));

  a_r8_idle_nop: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (cmdOut == 2'd0));

endmodule

bind sdram_rw_guard sdram_rw_guard_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqIsWrite  (reqIsWrite),
  .burstCode   (burstCode),
  .casLat      (casLat),
  .reqAccept   (reqAccept),
  .cmdOut      (cmdOut),
  .writeReady  (writeReady),
  .dqRelease   (dqRelease),
  .unsupported (unsupported)
);

// File: tb/sdram_rw_guard_bench.sv
`timescale 1ns/1ps
module sdram_rw_guard_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       reqValid;
  logic       reqIsWrite;
  logic [2:0] burstCode;
  logic [1:0] casLat;
  logic       reqAccept;
  logic [1:0] cmdOut;
  logic       writeReady;
  logic       dqRelease;
  logic       unsupported;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sdram_rw_guard u_sdram_rw_guard (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqIsWrite  (reqIsWrite),
    .burstCode   (burstCode),
    .casLat      (casLat),
    .reqAccept   (reqAccept),
    .cmdOut      (cmdOut),
    .writeReady  (writeReady),
    .dqRelease   (dqRelease),
    .unsupported (unsupported)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // read, then a write presented from read-cycle offset d on
  task automatic runCase(input int code, input int d);
    int bl, expS, expW, expCmd, expDq, expRdy;
    bit full;
    full = (code >= 4);
    bl   = full ? 0 : (1 << code);
    expS = d + 1;
    expW = full ? d + 4 : ((d > bl) ? d : bl) + 1;
    @(negedge clk);
    reqValid = 1'b1; reqIsWrite = 1'b0; burstCode = 3'(code);
    #0.5;
    chk(reqAccept == 1'b1, "R1 read accept", int'(reqAccept), 1);
    @(posedge clk); #0.5;
    chk(cmdOut == 2'd1, "R1 READ issued", int'(cmdOut), 1);
    for (int k = 0; k < 40; k++) begin
      int g;
      g = k + 1;
      @(negedge clk);
      reqIsWrite = 1'b1;
      reqValid   = (k >= d) && (k < expW);
      @(posedge clk); #0.5;
      if (full) expCmd = (g == expS) ? 3 : ((g == expW) ? 2 : 0);
      else      expCmd = (g == expW) ? 2 : 0;
      expDq = (!full && g >= expW && g <= bl + 2) ? 1 : 0;
      if (full) expRdy = (g >= expS + 2) ? 1 : 0;
      else      expRdy = (g >= bl) ? 1 : 0;
      if (full) chk(int'(cmdOut) == expCmd, "R4 stop then write", int'(cmdOut), expCmd);
      else      chk(int'(cmdOut) == expCmd, "R2/R3 write spacing", int'(cmdOut), expCmd);
      chk(int'(dqRelease) == expDq, "R7 release window", int'(dqRelease), expDq);
      chk(int'(writeReady) == expRdy, "R5 writeReady", int'(writeReady), expRdy);
      if (g >= expW + 3) break;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqIsWrite = 1'b0; burstCode = 3'd0; casLat = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #0.5;
    chk(cmdOut == 2'd0, "R8 reset cmd", int'(cmdOut), 0);
    chk(dqRelease == 1'b0, "R8 reset release", int'(dqRelease), 0);
    chk(writeReady == 1'b1, "R8 reset ready", int'(writeReady), 1);
    chk(unsupported == 1'b0, "R6 flag low", int'(unsupported), 0);
    @(posedge clk); #0.5;
    chk(cmdOut == 2'd0, "R8 idle nop", int'(cmdOut), 0);

    // write with no read history goes at once
    @(negedge clk); reqValid = 1'b1; reqIsWrite = 1'b1;
    #0.5;
    chk(reqAccept == 1'b1, "R5 first write accept", int'(reqAccept), 1);
    @(posedge clk); #0.5;
    chk(cmdOut == 2'd2, "R5 first write issued", int'(cmdOut), 2);
    chk(dqRelease == 1'b0, "R7 no read no release", int'(dqRelease), 0);
    @(negedge clk); reqValid = 1'b0;

    for (int code = 0; code < 4; code++)
      for (int d = 0; d <= (1 << code) + 2; d++)
        runCase(code, d);
    runCase(4, 0);
    runCase(4, 2);
    runCase(7, 5);

    // unsupported latency holds writes, reads still pass
    @(negedge clk); casLat = 2'd2; reqValid = 1'b1; reqIsWrite = 1'b0; burstCode = 3'd1;
    #0.5;
    chk(unsupported == 1'b1, "R6 flag high", int'(unsupported), 1);
    @(posedge clk); #0.5;
    chk(cmdOut == 2'd1, "R6 read still issued", int'(cmdOut), 1);
    @(negedge clk); reqIsWrite = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #0.5;
      chk(writeReady == 1'b0, "R6 ready low", int'(writeReady), 0);
      chk(reqAccept == 1'b0, "R6 write held", int'(reqAccept), 0);
      @(posedge clk); #0.5;
      chk(cmdOut == 2'd0, "R6 no write", int'(cmdOut), 0);
      @(negedge clk);
    end
    casLat = 2'd3;
    @(posedge clk); #0.5;
    chk(cmdOut == 2'd2, "R6 held write released", int'(cmdOut), 2);
    chk(dqRelease == 1'b0, "R7 late write no release", int'(dqRelease), 0);
    @(negedge clk); reqValid = 1'b0;
    @(posedge clk); #0.5;
    chk(cmdOut == 2'd0, "R8 idle after write", int'(cmdOut), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired R8 actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule